// File: doc/BRIEF.md
# Multi-Mode Eight-Channel Sample Serializer

This block sits behind an eight-channel converter array. Once per sample period it captures a 6-bit word from every channel and presents the set in one of three output formats, picked at run time. The first is a 6-bit parallel port that carries one selected channel. The second gives each channel its own serial lane. The third sends all 48 bits on one combined lane. The block has no fast clock of its own. A single-cycle fast-clock enable, supplied from outside, marks each output bit slot. The system must provide 6 enables per sample strobe for the per-channel lanes and 48 per strobe for the combined lane.

An internal pattern source can take the place of the converter words. It offers two patterns: a 6-bit binary counter shared by all channels, or a 7-bit pseudo-random sequence that is mixed with each channel's index. With it, the whole output path can be checked without live converter data. Format and channel changes take effect only at a sample strobe, so a frame is never split.

Top module: `sample_serializer`

## Requirements
- R1: While reset is asserted and after its release, before any sample strobe, every output (parOut, laneOut, fullOut) is 0.
- R2: The format code on modeSel is 0 for the parallel port, 1 for per-channel lanes, 2 for the combined lane and 3 for idle (every output 0). The code and chanSel are captured only in a cycle with sampleStrobe high.
- R3: In parallel format, parOut holds the word of the captured channel from the strobe edge until the next strobe. fastTick has no effect on it.
- R4: In per-channel format, lane c (laneOut[c]) shows bit 5 of channel c's word after the strobe edge. Each later fastTick edge without a strobe moves it one bit toward bit 0. After six ticks the lane reads 0.
- R5: In combined format, fullOut shows channel 0 bit 5 after the strobe edge. Each fastTick edge without a strobe advances it one bit, in the order channel 0 bits 5..0, then channel 1, and so on up to channel 7 bit 0. After 48 ticks it reads 0.
- R6: Outputs that the captured format does not use are held at 0.
- R7: A change of modeSel or chanSel between strobes has no effect on any output until the next strobe.
- R8: When fastTick and sampleStrobe are high in the same cycle, the strobe wins: a new frame is loaded and no shift takes place.
- R9: With patEn=1 and patType=0, every channel's word is a 6-bit counter value. The counter is 0 at the first strobe after reset and increments by one, wrapping, at every strobe, whether or not patEn is set.
- R10: With patEn=1 and patType=1, channel c's word is bits 5..0 of a 7-bit register XORed with c. The register is seeded to 7'b0000001 at reset. At every strobe it moves to {s[5:0], s[6]^s[5]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanData | input | 48 | Eight 6-bit converter words, channel c in bits [6c+5:6c] |
| sampleStrobe | input | 1 | One-cycle frame load strobe, once per sample period |
| fastTick | input | 1 | One-cycle bit-slot enable |
| modeSel | input | 2 | Output format code, captured at strobe |
| chanSel | input | 3 | Channel shown on the parallel port, captured at strobe |
| patEn | input | 1 | Replace converter words with the internal pattern |
| patType | input | 1 | Pattern kind: 0 counter, 1 pseudo-random |
| parOut | output | 6 | Parallel word of the selected channel |
| laneOut | output | 8 | Per-channel serial lanes, lane c carries channel c |
| fullOut | output | 1 | Combined serial lane |

## Verification
A wrong shift count or a segment boundary that leaks shows up as a wrong bit on a lane at the very next tick. The reference tracks the expected bit slot of every lane and compares it on every cycle. A captured format or channel that is out of step with the strobe shows up in the first cycle after the strobe edge: bits appear on lanes that should be idle, or the parallel word is the wrong one. A pattern register that starts from the wrong seed or steps at the wrong time shows up in the first frame loaded with the pattern source enabled, and stays visible from then on.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DEF_NCH   = 8;
  localparam int DEF_WBITS = 6;

  typedef enum logic [1:0] {
    MODE_PAR  = 2'd0,
    MODE_LANE = 2'd1,
    MODE_FULL = 2'd2,
    MODE_IDLE = 2'd3
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  load;
    logic  shiftSeg;
    logic  shiftAll;
    mode_e mode;
  } ctrl_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int NCH = DEF_NCH,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sampleStrobe,
  input  logic           fastTick,
  input  logic [1:0]     modeSel,
  input  logic [CHW-1:0] chanSel,
  output ctrl_t          ctrl,
  output logic [CHW-1:0] chanQ
);
  mode_e modeQ;

  // format and channel are frame-aligned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_PAR;
      chanQ <= '0;
    end else if (sampleStrobe) begin
      modeQ <= mode_e'(modeSel);
      chanQ <= chanSel;
    end
  end

  always_comb begin
    ctrl.load     = sampleStrobe;
    ctrl.shiftSeg = fastTick && !sampleStrobe && (modeQ == MODE_LANE);
    ctrl.shiftAll = fastTick && !sampleStrobe && (modeQ == MODE_FULL);
    ctrl.mode     = modeQ;
  end
endmodule

// File: rtl/ser_pattern.sv
module ser_pattern #(
  parameter int NCH    = ser_pkg::DEF_NCH,
  parameter int WBITS  = ser_pkg::DEF_WBITS,
  parameter int LFSR_W = 7,
  localparam int FRAME = NCH * WBITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             advance,
  input  logic             patType,
  output logic [FRAME-1:0] patWords
);
  logic [WBITS-1:0]  cntQ;
  logic [LFSR_W-1:0] lfsrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      lfsrQ <= LFSR_W'(1);
    end else if (advance) begin
      cntQ  <= cntQ + 1'b1;
      lfsrQ <= {lfsrQ[LFSR_W-2:0], lfsrQ[LFSR_W-1] ^ lfsrQ[LFSR_W-2]};
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : gChan
    assign patWords[c*WBITS +: WBITS] =
      patType ? (lfsrQ[WBITS-1:0] ^ WBITS'(c)) : cntQ;
  end
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int NCH   = DEF_NCH,
  parameter int WBITS = DEF_WBITS,
  localparam int FRAME = NCH * WBITS,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [CHW-1:0]   chanQ,
  input  logic [FRAME-1:0] chanData,
  input  logic             patEn,
  input  logic [FRAME-1:0] patWords,
  output logic [WBITS-1:0] parOut,
  output logic [NCH-1:0]   laneOut,
  output logic             fullOut
);
  logic [FRAME-1:0] frameQ, frameLoad, frameSeg;
  logic [FRAME-1:0] srcWords;

  assign srcWords = patEn ? patWords : chanData;

  // channel 0 sits at the top of the frame so it leaves first
  for (genvar c = 0; c < NCH; c++) begin : gSeg
    localparam int HI = FRAME - 1 - c * WBITS;
    assign frameLoad[HI -: WBITS] = srcWords[c*WBITS +: WBITS];
    assign frameSeg[HI -: WBITS]  = {frameQ[HI-1 -: WBITS-1], 1'b0};
    assign laneOut[c] = (ctrl.mode == MODE_LANE) && frameQ[HI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              frameQ <= '0;
    else if (ctrl.load)     frameQ <= frameLoad;
    else if (ctrl.shiftSeg) frameQ <= frameSeg;
    else if (ctrl.shiftAll) frameQ <= {frameQ[FRAME-2:0], 1'b0};
  end

  always_comb begin
    parOut = '0;
    if (ctrl.mode == MODE_PAR)
      parOut = frameQ[FRAME - 1 - int'(chanQ) * WBITS -: WBITS];
  end

  assign fullOut = (ctrl.mode == MODE_FULL) && frameQ[FRAME-1];
endmodule

// File: rtl/sample_serializer.sv
module sample_serializer #(
  parameter int NCH   = 8,
  parameter int WBITS = 6,
  localparam int FRAME = NCH * WBITS,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FRAME-1:0] chanData,
  input  logic             sampleStrobe,
  input  logic             fastTick,
  input  logic [1:0]       modeSel,
  input  logic [CHW-1:0]   chanSel,
  input  logic             patEn,
  input  logic             patType,
  output logic [WBITS-1:0] parOut,
  output logic [NCH-1:0]   laneOut,
  output logic             fullOut
);
  ser_pkg::ctrl_t   ctrl;
  logic [CHW-1:0]   chanQ;
  logic [FRAME-1:0] patWords;

  ser_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .fastTick(fastTick),
    .modeSel(modeSel), .chanSel(chanSel), .ctrl(ctrl), .chanQ(chanQ)
  );

  ser_pattern #(.NCH(NCH), .WBITS(WBITS)) u_pat (
    .clk(clk), .rstN(rstN), .advance(sampleStrobe), .patType(patType),
    .patWords(patWords)
  );

  ser_datapath #(.NCH(NCH), .WBITS(WBITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .chanQ(chanQ), .chanData(chanData),
    .patEn(patEn), .patWords(patWords), .parOut(parOut), .laneOut(laneOut),
    .fullOut(fullOut)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int NCH   = 8,
  parameter int WBITS = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStrobe,
  input logic             fastTick,
  input logic [1:0]       modeSel,
  input logic [WBITS-1:0] parOut,
  input logic [NCH-1:0]   laneOut,
  input logic             fullOut
);
  logic [1:0] seenMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             seenMode <= 2'd0;
    else if (sampleStrobe) seenMode <= modeSel;
  end

  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (seenMode != 2'd1) |-> (laneOut == '0));  // R6
  AST_FULL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (seenMode != 2'd2) |-> !fullOut);  // R6
  AST_PAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (seenMode != 2'd0) |-> (parOut == '0));  // R6
  AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (seenMode == 2'd0 && !sampleStrobe) |=> $stable(parOut));  // R3
  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (seenMode == 2'd1 && !sampleStrobe && !fastTick) |=> $stable(laneOut));  // R4
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (seenMode == 2'd2 && !sampleStrobe && !fastTick) |=> $stable(fullOut));  // R5
endmodule

bind sample_serializer ser_checker #(.NCH(NCH), .WBITS(WBITS)) u_chk (
  .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .fastTick(fastTick),
  .modeSel(modeSel), .parOut(parOut), .laneOut(laneOut), .fullOut(fullOut)
);

// File: tb/sample_serializer_tb.sv
`timescale 1ns/1ps
module sample_serializer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [47:0] chanData = '0;
  logic        sampleStrobe = 1'b0, fastTick = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [2:0]  chanSel = 3'd0;
  logic        patEn = 1'b0, patType = 1'b0;
  logic [5:0]  parOut;
  logic [7:0]  laneOut;
  logic        fullOut;

  int tests = 0, fails = 0;

  // reference state
  int       mMode = 0, mChan = 0, laneIdx = 0, fullIdx = 0;
  int       mCnt = 0, mLfsr = 1;
  bit [5:0] mWord [8];

  always #10 clk = ~clk;

  sample_serializer u_dut (
    .clk(clk), .rstN(rstN), .chanData(chanData), .sampleStrobe(sampleStrobe),
    .fastTick(fastTick), .modeSel(modeSel), .chanSel(chanSel), .patEn(patEn),
    .patType(patType), .parOut(parOut), .laneOut(laneOut), .fullOut(fullOut)
  );

  task automatic check(input string tag);
    logic [5:0] ePar;
    logic [7:0] eLane;
    logic       eFull;
    ePar  = (mMode == 0) ? mWord[mChan] : 6'd0;
    for (int c = 0; c < 8; c++)
      eLane[c] = (mMode == 1 && laneIdx < 6) ? mWord[c][5-laneIdx] : 1'b0;
    eFull = (mMode == 2 && fullIdx < 48) ? mWord[fullIdx/6][5-(fullIdx%6)] : 1'b0;
    tests += 3;
    if (parOut !== ePar) begin
      fails++; $display("FAIL %s parOut: got %h expected %h", tag, parOut, ePar);
    end
    if (laneOut !== eLane) begin
      fails++; $display("FAIL %s laneOut: got %b expected %b", tag, laneOut, eLane);
    end
    if (fullOut !== eFull) begin
      fails++; $display("FAIL %s fullOut: got %b expected %b", tag, fullOut, eFull);
    end
  endtask

  // drive one cycle from a falling edge, update the model, compare at the next falling edge
  task automatic step(input bit stb, input bit tk, input string tag);
    sampleStrobe = stb;
    fastTick     = tk;
    if (stb) begin
      for (int c = 0; c < 8; c++) begin
        if (!patEn)       mWord[c] = chanData[c*6 +: 6];
        else if (patType) mWord[c] = 6'(mLfsr & 63) ^ 6'(c);
        else              mWord[c] = 6'(mCnt);
      end
      mCnt  = (mCnt + 1) & 63;
      mLfsr = ((mLfsr << 1) & 127) | (((mLfsr >> 6) ^ (mLfsr >> 5)) & 1);
      mMode = modeSel; mChan = chanSel; laneIdx = 0; fullIdx = 0;
    end else if (tk) begin
      if (mMode == 1) laneIdx++;
      if (mMode == 2) fullIdx++;
    end
    @(negedge clk);
    sampleStrobe = 1'b0;
    fastTick     = 1'b0;
    check(tag);
  endtask

  task automatic frame(input int mode, input int chan, input int nTicks,
                       input string tag);
    modeSel  = 2'(mode);
    chanSel  = 3'(chan);
    chanData = {$urandom, $urandom} [47:0];
    step(1'b1, 1'b0, tag);
    for (int t = 0; t < nTicks; t++) begin
      if (t % 4 == 3) step(1'b0, 1'b0, tag);  // idle gap between ticks
      step(1'b0, 1'b1, tag);
    end
  endtask

  initial begin
    #4_000_000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: outputs zero during and after reset
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    step(1'b0, 1'b1, "R1");
    step(1'b0, 1'b0, "R1");

    // R3: parallel port over every channel, ticks ignored
    for (int ch = 0; ch < 8; ch++) frame(0, ch, 5, "R3");

    // R4 and R6: per-channel lanes, overrun ticks give zeros
    for (int k = 0; k < 4; k++) frame(1, 0, 9, "R4");

    // R5 and R6: combined lane, overrun ticks give zeros
    for (int k = 0; k < 3; k++) frame(2, 0, 52, "R5");

    // R2: idle code, all outputs zero
    frame(3, 2, 8, "R2");

    // R7: select changes mid-frame have no effect
    frame(1, 0, 2, "R7");
    modeSel = 2'd2; chanSel = 3'd5;
    step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b1, "R7");
    frame(0, 4, 1, "R7");
    chanSel = 3'd1; modeSel = 2'd1;
    step(1'b0, 1'b1, "R7");

    // R8: strobe together with a tick loads, no shift
    frame(2, 0, 3, "R8");
    chanData = 48'hA5C3_0F96_3C5A;
    sampleStrobe = 1'b1;
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, "R8");
    modeSel = 2'd1;
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, "R8");

    // R9: counter pattern, wrapping past 63
    patEn = 1'b1; patType = 1'b0;
    for (int k = 0; k < 70; k++) frame(k % 3, k % 8, 7, "R9");

    // R10: pseudo-random pattern, full period and beyond
    patType = 1'b1;
    for (int k = 0; k < 20; k++) frame(2, 0, 48, "R10");
    for (int k = 0; k < 130; k++) frame(k % 2, k % 8, 6, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule